// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Condition-Code Register

This block is the execute-stage arithmetic/logic unit of a small 16-bit register-to-register processor, together with the condition-code register that holds its status flags. It takes two register operands, or one register operand and a 5-bit signed constant from the instruction, and produces a 16-bit result combinationally in the same cycle. Arithmetic uses two's-complement numbers. Logic operations treat the operands as plain bit vectors.

Only arithmetic operations update the stored flags. The flags are negative (N), zero (Z), carry (C) and overflow (V). An update happens on the rising clock edge when the flag-write enable is high. Logic operations leave the flags alone, so a later conditional branch always sees the status of the most recent add or subtract. Opcode decoding, the register file and memory access are not part of this block.

Top module: `arith_flag_unit`

## Requirements
- R1: With `opSel` = 0 (ADD), `result` equals `opA` plus the second operand, modulo 2^16, in the same cycle.
- R2: With `opSel` = 1 (SUB), `result` equals `opA` minus the second operand, computed as `opA` + ~operand + 1, modulo 2^16.
- R3: When `useImm` is 1 and the operation is ADD or SUB, the second operand is `immField` sign-extended from 5 bits (range -16 to +15) and `opB` is ignored. When `useImm` is 0, the second operand is `opB`.
- R4: The logic codes are 2 = AND, 3 = OR, 4 = XOR, 5 = NOT of `opA`, 6 = pass `opA` and 7 = pass `opB`. All of them operate bitwise on `opA` and `opB`, and `useImm` has no effect on them.
- R5: After a rising edge on which `flagWe` is 1 and the operation is ADD or SUB, `flagN` equals bit 15 of that cycle's result, and `flagZ` is 1 exactly when that result was zero.
- R6: After such an edge, `flagC` equals the carry out of bit 15 of the addition (for SUB, of `opA` + ~operand + 1).
- R7: After such an edge, `flagV` equals the XOR of the carry into bit 15 and the carry out of bit 15, which is signed overflow.
- R8: A logic operation (codes 2 to 7) leaves all four flags unchanged, even when `flagWe` is 1.
- R9: While `flagWe` is 0, all four flags hold their values whatever the operation.
- R10: While `rstN` is 0, all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset of the flag register |
| opSel | input | 3 | Operation code (0 ADD, 1 SUB, 2 AND, 3 OR, 4 XOR, 5 NOT A, 6 pass A, 7 pass B) |
| useImm | input | 1 | Selects the sign-extended immediate as second arithmetic operand |
| opA | input | 16 | First operand |
| opB | input | 16 | Second register operand |
| immField | input | 5 | Signed 5-bit immediate constant |
| flagWe | input | 1 | Flag-write enable for this cycle's operation |
| result | output | 16 | Combinational result |
| flagN | output | 1 | Stored negative flag |
| flagZ | output | 1 | Stored zero flag |
| flagC | output | 1 | Stored carry flag |
| flagV | output | 1 | Stored overflow flag |

## Verification
The result has no register on its path, so it is due in the same cycle as the operands. The bench drives inputs on the falling edge and compares `result` a short delay later, before the next rising edge. The flags pass through one register and are due one edge after the operation that sets them. They are therefore compared just after that rising edge, against a behavioural model that updates its flags only on that edge. The stimulus covers the overflow and carry corners of add and subtract at the positive and negative limits, both ends of the immediate range, and logic and disabled-write cycles used to show that the flags persist, followed by a long random run.

// File: rtl/afu_pkg.sv
package afu_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_AND   = 3'd2,
    OP_OR    = 3'd3,
    OP_XOR   = 3'd4,
    OP_NOTA  = 3'd5,
    OP_PASSA = 3'd6,
    OP_PASSB = 3'd7
  } aluOp_e;

  typedef enum logic [2:0] {
    LF_AND   = 3'd0,
    LF_OR    = 3'd1,
    LF_XOR   = 3'd2,
    LF_NOT   = 3'd3,
    LF_PASSA = 3'd4,
    LF_PASSB = 3'd5
  } logicFn_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     arith;   // result comes from the adder
    logic     invB;    // invert second operand and inject carry-in
    logic     selImm;  // second adder operand is the immediate
    logicFn_e logicFn; // bitwise function when not arithmetic
  } strobe_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/afu_ctrl.sv
module afu_ctrl
  import afu_pkg::*;
(
  input  logic [2:0] opSel,
  input  logic       useImm,
  input  logic       flagWe,
  output strobe_t    strobe,
  output logic       ccrLoad
);

  aluOp_e op;
  logic   isArith;

  always_comb begin
    op      = aluOp_e'(opSel);
    isArith = (op == OP_ADD) || (op == OP_SUB);
  end

  always_comb begin
    strobe.arith  = isArith;
    strobe.invB   = (op == OP_SUB);
    strobe.selImm = isArith & useImm;
    unique case (op)
      OP_AND:   strobe.logicFn = LF_AND;
      OP_OR:    strobe.logicFn = LF_OR;
      OP_XOR:   strobe.logicFn = LF_XOR;
      OP_NOTA:  strobe.logicFn = LF_NOT;
      OP_PASSA: strobe.logicFn = LF_PASSA;
      OP_PASSB: strobe.logicFn = LF_PASSB;
      default:  strobe.logicFn = LF_PASSA;
    endcase
  end

  assign ccrLoad = flagWe & isArith;

endmodule

// File: rtl/afu_dp.sv
module afu_dp
  import afu_pkg::*;
#(
  parameter int DW   = 16,
  parameter int IMMW = 5
) (
  input  strobe_t         strobe,
  input  logic [DW-1:0]   opA,
  input  logic [DW-1:0]   opB,
  input  logic [IMMW-1:0] immField,
  output logic [DW-1:0]   result,
  output flags_t          flagsNext
);

  localparam int EXTW = DW - IMMW;

  logic [DW-1:0] immExt;
  logic [DW-1:0] addB;
  logic [DW-1:0] addBAdj;
  logic [DW-1:0] lowSum;
  logic [1:0]    topSum;
  logic [DW-1:0] sum;
  logic          carryIn15;
  logic          carryOut;
  logic [DW-1:0] logicRes;

  generate
    if (EXTW > 0) begin : g_ext
      assign immExt = {{EXTW{immField[IMMW-1]}}, immField};
    end else begin : g_noext
      assign immExt = immField[DW-1:0];
    end
  endgenerate

  assign addB    = strobe.selImm ? immExt : opB;
  assign addBAdj = strobe.invB ? ~addB : addB;

  // split adder exposes the carry into and out of the top stage
  assign lowSum    = {1'b0, opA[DW-2:0]} + {1'b0, addBAdj[DW-2:0]}
                   + {{(DW-1){1'b0}}, strobe.invB};
  assign carryIn15 = lowSum[DW-1];
  assign topSum    = {1'b0, opA[DW-1]} + {1'b0, addBAdj[DW-1]} + {1'b0, carryIn15};
  assign carryOut  = topSum[1];
  assign sum       = {topSum[0], lowSum[DW-2:0]};

  always_comb begin
    unique case (strobe.logicFn)
      LF_AND:   logicRes = opA & opB;
      LF_OR:    logicRes = opA | opB;
      LF_XOR:   logicRes = opA ^ opB;
      LF_NOT:   logicRes = ~opA;
      LF_PASSA: logicRes = opA;
      LF_PASSB: logicRes = opB;
      default:  logicRes = opA;
    endcase
  end

  assign result = strobe.arith ? sum : logicRes;

  always_comb begin
    flagsNext.n = sum[DW-1];
    flagsNext.z = (sum == '0);
    flagsNext.c = carryOut;
    flagsNext.v = carryOut ^ carryIn15;
  end

endmodule

// File: rtl/afu_ccr.sv
module afu_ccr
  import afu_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   load,
  input  flags_t flagsNext,
  output flags_t flagsQ
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= '0;
    end else if (load) begin
      flagsQ <= flagsNext;
    end
  end

endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import afu_pkg::*;
#(
  parameter int DW   = 16,
  parameter int IMMW = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [2:0]      opSel,
  input  logic            useImm,
  input  logic [DW-1:0]   opA,
  input  logic [DW-1:0]   opB,
  input  logic [IMMW-1:0] immField,
  input  logic            flagWe,
  output logic [DW-1:0]   result,
  output logic            flagN,
  output logic            flagZ,
  output logic            flagC,
  output logic            flagV
);

  strobe_t strobe;
  logic    ccrLoad;
  flags_t  flagsNext;
  flags_t  flagsQ;

  afu_ctrl u_ctrl (
    .opSel   (opSel),
    .useImm  (useImm),
    .flagWe  (flagWe),
    .strobe  (strobe),
    .ccrLoad (ccrLoad)
  );

  afu_dp #(.DW(DW), .IMMW(IMMW)) u_dp (
    .strobe    (strobe),
    .opA       (opA),
    .opB       (opB),
    .immField  (immField),
    .result    (result),
    .flagsNext (flagsNext)
  );

  afu_ccr u_ccr (
    .clk       (clk),
    .rstN      (rstN),
    .load      (ccrLoad),
    .flagsNext (flagsNext),
    .flagsQ    (flagsQ)
  );

  assign flagN = flagsQ.n;
  assign flagZ = flagsQ.z;
  assign flagC = flagsQ.c;
  assign flagV = flagsQ.v;

endmodule

// File: rtl/afu_checker.sv
module afu_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic [2:0]    opSel,
  input logic          flagWe,
  input logic [DW-1:0] result,
  input logic          flagN,
  input logic          flagZ,
  input logic          flagC,
  input logic          flagV
);

  logic isLogic;
  assign isLogic = (opSel > 3'd1);

  p_neg_from_result_r5: assert property (@(posedge clk) disable iff (!rstN)
    (flagWe && !isLogic) |=> (flagN == $past(result[DW-1])));

  p_zero_from_result_r5: assert property (@(posedge clk) disable iff (!rstN)
    (flagWe && !isLogic) |=> (flagZ == ($past(result) == '0)));

  p_logic_keeps_flags_r8: assert property (@(posedge clk) disable iff (!rstN)
    isLogic |=> ($stable(flagN) && $stable(flagZ) && $stable(flagC) && $stable(flagV)));

  p_no_write_keeps_flags_r9: assert property (@(posedge clk) disable iff (!rstN)
    !flagWe |=> ($stable(flagN) && $stable(flagZ) && $stable(flagC) && $stable(flagV)));

  // R10: flags clear while reset is held
  always @(negedge clk) begin
    if (!rstN) begin
      p_reset_clear_r10: assert ({flagN, flagZ, flagC, flagV} == 4'b0000);
    end
  end

endmodule

bind arith_flag_unit afu_checker #(.DW(DW)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .opSel  (opSel),
  .flagWe (flagWe),
  .result (result),
  .flagN  (flagN),
  .flagZ  (flagZ),
  .flagC  (flagC),
  .flagV  (flagV)
);

// File: tb/sim_arith_flag_unit.sv
module sim_arith_flag_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opSel = 3'd0;
  logic        useImm = 1'b0;
  logic [15:0] opA = 16'h0;
  logic [15:0] opB = 16'h0;
  logic [4:0]  immField = 5'h0;
  logic        flagWe = 1'b0;
  logic [15:0] result;
  logic        flagN, flagZ, flagC, flagV;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model flags {N,Z,C,V}
  logic [3:0] mFlags = 4'b0000;

  always #10 clk = ~clk;

  arith_flag_unit u0 (
    .clk(clk), .rstN(rstN), .opSel(opSel), .useImm(useImm),
    .opA(opA), .opB(opB), .immField(immField), .flagWe(flagWe),
    .result(result), .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one operation: drive, check result same cycle, check flags after edge
  task automatic step(input int op, input bit imm, input int a, input int b,
                      input int immv, input bit we, input string req);
    int secondOp;
    int bb;
    int full;
    int r;
    bit arith;
    logic [3:0] newFlags;
    @(negedge clk);
    opSel = op[2:0]; useImm = imm; opA = a[15:0]; opB = b[15:0];
    immField = immv[4:0]; flagWe = we;
    arith = (op == 0) || (op == 1);
    if (arith && imm) begin
      secondOp = (immv & 16) ? ((immv & 31) - 32) : (immv & 31);
      secondOp = secondOp & 16'hFFFF;
    end else begin
      secondOp = b & 16'hFFFF;
    end
    case (op)
      0: begin bb = secondOp; full = (a & 16'hFFFF) + bb; end
      1: begin bb = (~secondOp) & 16'hFFFF; full = (a & 16'hFFFF) + bb + 1; end
      2: full = a & b;
      3: full = a | b;
      4: full = a ^ b;
      5: full = ~a;
      6: full = a;
      default: full = b;
    endcase
    r = full & 16'hFFFF;
    #2;
    check(req, {16'h0, result}, r[31:0]);
    if (arith) begin
      newFlags[3] = r[15];
      newFlags[2] = (r == 0);
      newFlags[1] = full[16];
      newFlags[0] = (a[15] == bb[15]) && (r[15] != a[15]);
    end else begin
      newFlags = mFlags;
    end
    @(posedge clk);
    if (we) mFlags = newFlags;
    #1;
    check({req, " flags"}, {28'h0, flagN, flagZ, flagC, flagV}, {28'h0, mFlags});
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset clears flags
    #1 check("R10 reset", {28'h0, flagN, flagZ, flagC, flagV}, 32'h0);
    @(negedge clk); rstN = 1'b1;

    // R1 R6 R7: add corners
    step(0, 0, 16'h7FFF, 16'h0001, 0, 1, "R1 R7 add pos overflow");
    step(0, 0, 16'hFFFF, 16'h0001, 0, 1, "R1 R6 add carry zero");
    step(0, 0, 16'h8000, 16'h8000, 0, 1, "R1 R6 R7 add neg overflow");
    step(0, 0, 16'h1234, 16'h0F0F, 0, 1, "R1 R5 add plain");
    // R2: subtract corners
    step(1, 0, 16'h8000, 16'h0001, 0, 1, "R2 R7 sub neg overflow");
    step(1, 0, 16'h0000, 16'h0001, 0, 1, "R2 R6 sub borrow");
    step(1, 0, 16'h0005, 16'h0005, 0, 1, "R2 R5 R6 sub equal");
    step(1, 0, 16'h7FFF, 16'hFFFF, 0, 1, "R2 R7 sub pos overflow");
    step(1, 0, 16'h0000, 16'h8000, 0, 1, "R2 R7 sub min");
    // R3: immediate range ends, opB ignored
    step(0, 1, 16'h0010, 16'hAAAA, 16, 1, "R3 imm -16");
    step(0, 1, 16'h7FF1, 16'h5555, 15, 1, "R3 R7 imm +15");
    step(1, 1, 16'h0000, 16'h1234, 31, 1, "R3 sub imm -1");
    // R4 R8: logic ops with write enabled keep flags
    step(2, 1, 16'hF0F0, 16'h3C3C, 3, 1, "R4 R8 and");
    step(3, 0, 16'hF0F0, 16'h3C3C, 0, 1, "R4 R8 or");
    step(4, 1, 16'hF0F0, 16'h3C3C, 7, 1, "R4 R8 xor");
    step(5, 0, 16'h0000, 16'h1111, 0, 1, "R4 R8 not");
    step(6, 0, 16'h0000, 16'hFFFF, 0, 1, "R4 R8 passA");
    step(7, 1, 16'hFFFF, 16'h0000, 9, 1, "R4 R8 passB");
    // R9: arithmetic with write disabled
    step(0, 0, 16'hFFFF, 16'h0001, 0, 0, "R9 add no write");
    step(1, 0, 16'h8000, 16'h0001, 0, 0, "R9 sub no write");

    for (int i = 0; i < 600; i++) begin
      step($urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 65535),
           $urandom_range(0, 65535), $urandom_range(0, 31), $urandom_range(0, 1),
           "R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule